// File: doc/BRIEF.md
# Read-Modify-Write Parity Merge Unit

This unit sits between a write requester and a 64-bit memory that keeps one parity bit for every byte lane. A write that covers the whole double word and can supply or produce all eight parity bits goes to memory in a single command. Any other write triggers a read-modify-write sequence, provided read-modify-write parity is enabled. The unit reads the stored double word and checks its parity. It then overlays the enabled bytes of the request, computes parity afresh over the merged word, and writes the data and all eight parity bits back.

Requests come from two kinds of source. A processor source supplies its own parity only on burst beats, so every single-beat processor write needs the sequence. A bus-bridge source gets its parity computed by the unit, so only bridge writes that miss some byte lanes need the sequence. When read-modify-write parity is disabled, every write is sent directly with its byte mask. A configuration pair can keep the memory page open across the whole sequence. A parity mismatch found in the read phase is reported with its address, and the write-back still goes ahead.

Top module: `rmw_parity_merge`

## Requirements
- R1: A processor request (req_src=0) with req_full=1 is written in the cycle after acceptance, with req_data, req_par unchanged and all eight lanes enabled (mem_wbe=8'hFF), and with no memory read.
- R2: A bridge request (req_src=1) with req_be=8'hFF is written in the cycle after acceptance, with unit-generated parity, mem_wbe=8'hFF and no memory read.
- R3: Generated parity bit i is the XOR of data bits [8i+7:8i], inverted when cfg_odd_par=1.
- R4: With cfg_rmw_en=1, any other request issues mem_rd for the latched address in the cycle after acceptance. Its write-back comes six cycles later than a direct write would, so seven cycles after acceptance when read data returns two cycles after mem_rd.
- R5: The write-back data takes byte lane i from the request where req_be[i]=1 and from the read data otherwise. It is written with mem_wbe=8'hFF and parity regenerated over the merged word.
- R6: If the parity read back differs from parity generated over the read data, err_valid is high for exactly one cycle, the cycle after the read data arrives, with err_addr equal to the request address. The write-back still occurs and uses the read data as fetched.
- R7: With cfg_rmw_en=0, every request is written in the cycle after acceptance with mem_wbe=req_be (8'hFF for a processor full request), generated parity (supplied parity for a processor full request) and no read.
- R8: req_ready is low from the cycle after acceptance until the write command cycle has ended; it is high again in the cycle following the write.
- R9: mem_page_hold is high in every cycle from the read through the write-back of a sequence exactly when cfg_hold_burst and cfg_hold_limit are both nonzero, and low in every other cycle.
- R10: After reset, req_ready is high and mem_rd, mem_wr and err_valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_rmw_en | input | 1 | Enables the read-modify-write path |
| cfg_odd_par | input | 1 | 1 selects odd parity, 0 even |
| cfg_hold_burst | input | 4 | Page retention setting, burst-to-close delay |
| cfg_hold_limit | input | 8 | Page retention setting, page limit |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle and able to accept |
| req_addr | input | ADDR_W | Double-word address |
| req_data | input | 64 | Write data |
| req_be | input | 8 | Byte lane enables |
| req_par | input | 8 | Parity supplied with a processor full request |
| req_full | input | 1 | Processor burst beat carrying its own parity |
| req_src | input | 1 | 0 processor, 1 bus bridge |
| mem_rd | output | 1 | Memory read command |
| mem_wr | output | 1 | Memory write command |
| mem_addr | output | ADDR_W | Command address |
| mem_wdata | output | 64 | Write data |
| mem_wpar | output | 8 | Write parity |
| mem_wbe | output | 8 | Write lane enables |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 64 | Read data |
| mem_rpar | input | 8 | Read parity |
| mem_page_hold | output | 1 | Keep the open row across the sequence |
| err_valid | output | 1 | Read parity mismatch pulse |
| err_addr | output | ADDR_W | Address of the mismatching word |

## Verification
The bench drives full bridge writes and self-parity processor bursts, which must reach memory in one cycle. It then drives low-nibble, single-byte, two-byte edge and all-lanes-but-not-burst partial writes, which must take the seven-cycle path. Comparing the written word against a shadow memory separates the lanes taken from the request from the lanes taken from the read, so a swapped or inverted mask shows up. A word stored with deliberately inverted parity, later merged, separates error reporting from the write-back that must still happen. Runs with odd polarity, with page retention off, and with the read-modify-write path disabled show that each setting changes only the parity, hold or latency it governs.

// File: rtl/rpm_pkg.sv
package rpm_pkg;
  localparam int DATA_W = 64;
  localparam int LANE_W = 8;
  localparam int LANES  = DATA_W / LANE_W;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DWR, ST_RD, ST_WAIT, ST_CHK, ST_MRG, ST_GEN, ST_RWR
  } seq_st_t;

  // one parity bit per lane, polarity flips the whole vector
  function automatic logic [LANES-1:0] lane_parity(input logic [DATA_W-1:0] d,
                                                   input logic odd);
    logic [LANES-1:0] p;
    for (int i = 0; i < LANES; i++) p[i] = (^d[i*LANE_W +: LANE_W]) ^ odd;
    return p;
  endfunction

  // lanes with enable set come from the new word
  function automatic logic [DATA_W-1:0] merge_lanes(input logic [DATA_W-1:0] old_d,
                                                    input logic [DATA_W-1:0] new_d,
                                                    input logic [LANES-1:0] en);
    logic [DATA_W-1:0] m;
    for (int i = 0; i < LANES; i++)
      m[i*LANE_W +: LANE_W] = en[i] ? new_d[i*LANE_W +: LANE_W] : old_d[i*LANE_W +: LANE_W];
    return m;
  endfunction
endpackage

// File: rtl/rpm_classify.sv
module rpm_classify
  import rpm_pkg::*;
(
  input  logic              rmw_en,
  input  logic              odd,
  input  logic [DATA_W-1:0] data,
  input  logic [LANES-1:0]  be,
  input  logic [LANES-1:0]  par,
  input  logic              full,
  input  logic              src,
  output logic              need_rmw,
  output logic [DATA_W-1:0] dir_data,
  output logic [LANES-1:0]  dir_par,
  output logic [LANES-1:0]  dir_be
);
  localparam logic [LANES-1:0] ALL_LANES = '1;

  logic cpu_full;
  logic bridge_full;

  always_comb begin
    cpu_full    = (src == 1'b0) && full;
    bridge_full = (src == 1'b1) && (be == ALL_LANES);
    need_rmw    = rmw_en && !(cpu_full || bridge_full);
    dir_data    = data;
    dir_par     = cpu_full ? par : lane_parity(data, odd);
    dir_be      = cpu_full ? ALL_LANES : be;
  end
endmodule

// File: rtl/rpm_seq.sv
module rpm_seq
  import rpm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic need_rmw,
  input  logic rvalid,
  output logic ready,
  output logic accept,
  output logic rd_cmd,
  output logic wr_cmd,
  output logic seq_active,
  output logic cap_en,
  output logic chk_en,
  output logic mrg_en,
  output logic gen_en
);
  seq_st_t st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (req_valid) st_d = need_rmw ? ST_RD : ST_DWR;
      ST_DWR:  st_d = ST_IDLE;
      ST_RD:   st_d = ST_WAIT;
      ST_WAIT: if (rvalid) st_d = ST_CHK;
      ST_CHK:  st_d = ST_MRG;
      ST_MRG:  st_d = ST_GEN;
      ST_GEN:  st_d = ST_RWR;
      ST_RWR:  st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  always_comb begin
    ready      = (st_q == ST_IDLE);
    accept     = ready && req_valid;
    rd_cmd     = (st_q == ST_RD);
    wr_cmd     = (st_q == ST_DWR) || (st_q == ST_RWR);
    seq_active = (st_q != ST_IDLE) && (st_q != ST_DWR);
    cap_en     = (st_q == ST_WAIT) && rvalid;
    chk_en     = (st_q == ST_CHK);
    mrg_en     = (st_q == ST_MRG);
    gen_en     = (st_q == ST_GEN);
  end
endmodule

// File: rtl/rpm_datapath.sv
module rpm_datapath
  import rpm_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              odd,
  input  logic              accept,
  input  logic              cap_en,
  input  logic              chk_en,
  input  logic              mrg_en,
  input  logic              gen_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] new_data,
  input  logic [LANES-1:0]  new_be,
  input  logic [DATA_W-1:0] dir_data,
  input  logic [LANES-1:0]  dir_par,
  input  logic [LANES-1:0]  dir_be,
  input  logic [DATA_W-1:0] rd_data,
  input  logic [LANES-1:0]  rd_par,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic [LANES-1:0]  wpar_q,
  output logic [LANES-1:0]  wbe_q,
  output logic              rd_mismatch,
  output logic              err_pulse
);
  logic [DATA_W-1:0] new_q;
  logic [LANES-1:0]  be_q;
  logic [DATA_W-1:0] rdat_q;
  logic [LANES-1:0]  rpar_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q  <= '0;
      new_q   <= '0;
      be_q    <= '0;
      wdata_q <= '0;
      wpar_q  <= '0;
      wbe_q   <= '0;
      rdat_q  <= '0;
      rpar_q  <= '0;
    end else begin
      if (accept) begin
        addr_q  <= addr;
        new_q   <= new_data;
        be_q    <= new_be;
        wdata_q <= dir_data;
        wpar_q  <= dir_par;
        wbe_q   <= dir_be;
      end
      if (cap_en) begin
        rdat_q <= rd_data;
        rpar_q <= rd_par;
      end
      if (mrg_en) begin
        wdata_q <= merge_lanes(rdat_q, new_q, be_q);
        wbe_q   <= '1;
      end
      if (gen_en) wpar_q <= lane_parity(wdata_q, odd);
    end
  end

  assign rd_mismatch = (lane_parity(rdat_q, odd) != rpar_q);
  assign err_pulse   = chk_en && rd_mismatch;
endmodule

// File: rtl/rmw_parity_merge.sv
module rmw_parity_merge
  import rpm_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_rmw_en,
  input  logic              cfg_odd_par,
  input  logic [3:0]        cfg_hold_burst,
  input  logic [7:0]        cfg_hold_limit,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [63:0]       req_data,
  input  logic [7:0]        req_be,
  input  logic [7:0]        req_par,
  input  logic              req_full,
  input  logic              req_src,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [63:0]       mem_wdata,
  output logic [7:0]        mem_wpar,
  output logic [7:0]        mem_wbe,
  input  logic              mem_rvalid,
  input  logic [63:0]       mem_rdata,
  input  logic [7:0]        mem_rpar,
  output logic              mem_page_hold,
  output logic              err_valid,
  output logic [ADDR_W-1:0] err_addr
);
  logic              need_rmw;
  logic [DATA_W-1:0] dir_data;
  logic [LANES-1:0]  dir_par;
  logic [LANES-1:0]  dir_be;
  logic              accept;
  logic              seq_active;
  logic              cap_en;
  logic              chk_en;
  logic              mrg_en;
  logic              gen_en;
  logic              rd_mismatch;
  logic              hold_cfg_on;
  logic [ADDR_W-1:0] addr_q;

  rpm_classify u_cls (
    .rmw_en   (cfg_rmw_en),
    .odd      (cfg_odd_par),
    .data     (req_data),
    .be       (req_be),
    .par      (req_par),
    .full     (req_full),
    .src      (req_src),
    .need_rmw (need_rmw),
    .dir_data (dir_data),
    .dir_par  (dir_par),
    .dir_be   (dir_be)
  );

  rpm_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .need_rmw   (need_rmw),
    .rvalid     (mem_rvalid),
    .ready      (req_ready),
    .accept     (accept),
    .rd_cmd     (mem_rd),
    .wr_cmd     (mem_wr),
    .seq_active (seq_active),
    .cap_en     (cap_en),
    .chk_en     (chk_en),
    .mrg_en     (mrg_en),
    .gen_en     (gen_en)
  );

  rpm_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .odd         (cfg_odd_par),
    .accept      (accept),
    .cap_en      (cap_en),
    .chk_en      (chk_en),
    .mrg_en      (mrg_en),
    .gen_en      (gen_en),
    .addr        (req_addr),
    .new_data    (req_data),
    .new_be      (req_be),
    .dir_data    (dir_data),
    .dir_par     (dir_par),
    .dir_be      (dir_be),
    .rd_data     (mem_rdata),
    .rd_par      (mem_rpar),
    .addr_q      (addr_q),
    .wdata_q     (mem_wdata),
    .wpar_q      (mem_wpar),
    .wbe_q       (mem_wbe),
    .rd_mismatch (rd_mismatch),
    .err_pulse   (err_valid)
  );

  assign hold_cfg_on   = (|cfg_hold_burst) && (|cfg_hold_limit);
  assign mem_page_hold = seq_active && hold_cfg_on;
  assign mem_addr      = addr_q;
  assign err_addr      = addr_q;
endmodule

// File: rtl/rpm_chk.sv
module rpm_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_ready,
  input logic       mem_rd,
  input logic       mem_wr,
  input logic [7:0] mem_wbe,
  input logic       mem_page_hold,
  input logic       err_valid,
  input logic       seq_active
);
  // R8
  wr_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |=> req_ready);

  // R4
  rd_then_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> (!mem_rd && !mem_wr && !req_ready));

  // R6
  err_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_valid |=> !err_valid);

  // R9
  hold_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_page_hold |-> !req_ready);

  // R5
  wb_all_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && seq_active) |-> (mem_wbe == 8'hFF));

  // R1
  rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));
endmodule

bind rmw_parity_merge rpm_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_ready     (req_ready),
  .mem_rd        (mem_rd),
  .mem_wr        (mem_wr),
  .mem_wbe       (mem_wbe),
  .mem_page_hold (mem_page_hold),
  .err_valid     (err_valid),
  .seq_active    (seq_active)
);

// File: tb/tb_rmw_parity_merge.sv
`timescale 1ns/1ps
module tb_rmw_parity_merge;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_rmw_en = 1'b1, cfg_odd_par = 1'b0;
  logic [3:0]  cfg_hold_burst = 4'd3;
  logic [7:0]  cfg_hold_limit = 8'd8;
  logic        req_valid = 1'b0, req_ready;
  logic [31:0] req_addr = '0;
  logic [63:0] req_data = '0;
  logic [7:0]  req_be = '0, req_par = '0;
  logic        req_full = 1'b0, req_src = 1'b0;
  logic        mem_rd, mem_wr, mem_page_hold, err_valid;
  logic [31:0] mem_addr, err_addr;
  logic [63:0] mem_wdata;
  logic [7:0]  mem_wpar, mem_wbe;
  logic        mem_rvalid = 1'b0;
  logic [63:0] mem_rdata = '0;
  logic [7:0]  mem_rpar = '0;

  always #2 clk = ~clk;

  rmw_parity_merge dut (.*);

  typedef struct { int cyc; logic [31:0] a; logic [63:0] d; logic [7:0] p; logic [7:0] be; string tag; } wr_t;
  typedef struct { int cyc; logic [31:0] a; string tag; } ev_t;
  wr_t wq[$];
  ev_t rq[$];
  ev_t eq[$];

  logic [63:0] mdata [logic [31:0]];
  logic [7:0]  mpar  [logic [31:0]];
  logic [63:0] sdata [logic [31:0]];
  logic [7:0]  spar  [logic [31:0]];

  int cyc = 0;
  int n_chk = 0, n_fail = 0;
  int hlo = -1, hhi = -2, rdy_cyc = -1;
  bit hexp = 1'b0;
  bit done = 1'b0;
  bit live = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // bench parity: count ones per lane
  function automatic logic [7:0] bpar(logic [63:0] d, logic odd);
    logic [7:0] p;
    for (int i = 0; i < 8; i++) p[i] = ($countones(d[i*8 +: 8]) % 2 == 1) ? ~odd : odd;
    return p;
  endfunction

  // memory model, read data two cycles after the read command
  logic p1 = 1'b0;
  logic [31:0] p1a = '0;
  always @(posedge clk) begin
    p1  <= mem_rd;
    p1a <= mem_addr;
    mem_rvalid <= p1;
    mem_rdata  <= mdata.exists(p1a) ? mdata[p1a] : 64'd0;
    mem_rpar   <= mpar.exists(p1a) ? mpar[p1a] : 8'd0;
    if (mem_wr) begin
      logic [63:0] od;
      logic [7:0]  op;
      od = mdata.exists(mem_addr) ? mdata[mem_addr] : 64'd0;
      op = mpar.exists(mem_addr) ? mpar[mem_addr] : 8'd0;
      for (int i = 0; i < 8; i++) if (mem_wbe[i]) begin
        od[i*8 +: 8] = mem_wdata[i*8 +: 8];
        op[i] = mem_wpar[i];
      end
      mdata[mem_addr] = od;
      mpar[mem_addr]  = op;
    end
  end

  task automatic send(logic [31:0] a, logic [63:0] d, logic [7:0] be, logic [7:0] p,
                      bit full, bit src, string tag);
    int n;
    bit cf, rmw;
    logic [63:0] od, md;
    logic [7:0]  op, ep;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_addr = a; req_data = d; req_be = be; req_par = p;
    req_full = full; req_src = src; req_valid = 1'b1;
    n  = cyc + 1;
    cf = (src == 1'b0 && full) || (src == 1'b1 && be == 8'hFF);
    rmw = cfg_rmw_en && !cf;
    od = sdata.exists(a) ? sdata[a] : 64'd0;
    op = spar.exists(a) ? spar[a] : 8'd0;
    if (!rmw) begin
      logic [7:0] wbe;
      wbe = (src == 1'b0 && full) ? 8'hFF : be;
      ep  = (src == 1'b0 && full) ? p : bpar(d, cfg_odd_par);
      wq.push_back('{n, a, d, ep, wbe, tag});
      for (int i = 0; i < 8; i++) if (wbe[i]) begin
        od[i*8 +: 8] = d[i*8 +: 8];
        op[i] = ep[i];
      end
      sdata[a] = od; spar[a] = op;
      rdy_cyc = n + 1;
    end else begin
      rq.push_back('{n, a, tag});
      if (bpar(od, cfg_odd_par) != op) eq.push_back('{n + 3, a, "R6"});
      for (int i = 0; i < 8; i++) md[i*8 +: 8] = be[i] ? d[i*8 +: 8] : od[i*8 +: 8];
      wq.push_back('{n + 6, a, md, bpar(md, cfg_odd_par), 8'hFF, tag});
      sdata[a] = md; spar[a] = bpar(md, cfg_odd_par);
      hlo = n; hhi = n + 6;
      hexp = (cfg_hold_burst != 0) && (cfg_hold_limit != 0);
      rdy_cyc = n + 7;
    end
    @(negedge clk);
    req_valid = 1'b0;
    // R8: busy right after acceptance
    chk(req_ready == 1'b0, "R8", "ready after accept", {63'd0, req_ready}, 64'd0);
  endtask

  task automatic settle();
    @(negedge clk);
    while (!req_ready || wq.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (live) begin
      if (mem_wr) begin
        if (wq.size() == 0) chk(1'b0, "R7", "unexpected write", {32'd0, mem_addr}, 64'd0);
        else begin
          wr_t e;
          e = wq.pop_front();
          chk(cyc == e.cyc, e.tag, "write cycle", 64'(cyc), 64'(e.cyc));
          chk(mem_addr == e.a, e.tag, "write addr", {32'd0, mem_addr}, {32'd0, e.a});
          chk(mem_wdata == e.d, e.tag, "write data", mem_wdata, e.d);
          chk(mem_wpar == e.p, (e.tag == "R1") ? "R1" : "R3", "write parity", {56'd0, mem_wpar}, {56'd0, e.p});
          chk(mem_wbe == e.be, e.tag, "write lanes", {56'd0, mem_wbe}, {56'd0, e.be});
        end
      end
      if (mem_rd) begin
        if (rq.size() == 0) chk(1'b0, "R7", "unexpected read", {32'd0, mem_addr}, 64'd0);
        else begin
          ev_t e;
          e = rq.pop_front();
          chk(cyc == e.cyc && mem_addr == e.a, "R4", "read cycle/addr", {cyc[31:0], mem_addr}, {e.cyc[31:0], e.a});
        end
      end
      if (err_valid) begin
        if (eq.size() == 0) chk(1'b0, "R6", "unexpected error", {32'd0, err_addr}, 64'd0);
        else begin
          ev_t e;
          e = eq.pop_front();
          chk(cyc == e.cyc && err_addr == e.a, "R6", "error cycle/addr", {cyc[31:0], err_addr}, {e.cyc[31:0], e.a});
        end
      end
      if (cyc >= hlo && cyc <= hhi)
        chk(mem_page_hold == hexp, "R9", "page hold in sequence", {63'd0, mem_page_hold}, {63'd0, hexp});
      else if (mem_page_hold)
        chk(1'b0, "R9", "page hold outside sequence", 64'd1, 64'd0);
      if (cyc == rdy_cyc)
        chk(req_ready == 1'b1, "R8", "ready after write", {63'd0, req_ready}, 64'd1);
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [63:0] bd;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10
    chk(req_ready == 1'b1, "R10", "ready after reset", {63'd0, req_ready}, 64'd1);
    chk(!mem_rd && !mem_wr && !err_valid, "R10", "idle commands", {61'd0, mem_rd, mem_wr, err_valid}, 64'd0);
    live = 1'b1;

    // R2 full bridge writes, R3 even parity
    send(32'h10, 64'h0123_4567_89AB_CDEF, 8'hFF, 8'h00, 1'b0, 1'b1, "R2");
    send(32'h18, 64'hF0E1_D2C3_B4A5_9687, 8'hFF, 8'h00, 1'b0, 1'b1, "R2");
    // R1 processor burst with its own (wrong) parity
    bd = 64'hFFFF_0000_AAAA_5557;
    send(32'h20, bd, 8'h00, ~bpar(bd, 1'b0), 1'b1, 1'b0, "R1");
    settle();
    // R4 R5 processor partial, page held
    send(32'h10, 64'h1111_2222_3333_4444, 8'h0F, 8'h00, 1'b0, 1'b0, "R5");
    settle();
    // R9 page retention off: bridge single byte
    cfg_hold_limit = 8'd0;
    send(32'h18, 64'h0000_00AB_0000_0000, 8'h10, 8'h00, 1'b0, 1'b1, "R4");
    settle();
    cfg_hold_limit = 8'd8;
    cfg_hold_burst = 4'd0;
    send(32'h18, 64'h0000_0000_0000_CD00, 8'h02, 8'h00, 1'b0, 1'b1, "R5");
    settle();
    cfg_hold_burst = 4'd3;
    // R4 processor single beat with all lanes still merges
    send(32'h18, 64'h5A5A_5A5A_5A5A_5A5A, 8'hFF, 8'h00, 1'b0, 1'b0, "R4");
    settle();
    // R6 merge into word stored with bad parity
    send(32'h20, 64'h7700_0000_0000_0066, 8'h81, 8'h00, 1'b0, 1'b0, "R6");
    settle();
    // R3 odd polarity
    cfg_odd_par = 1'b1;
    send(32'h30, 64'h8000_0001_FFFF_0F0F, 8'hFF, 8'h00, 1'b0, 1'b1, "R3");
    settle();
    send(32'h30, 64'h0000_1234_5600_0000, 8'h3C, 8'h00, 1'b0, 1'b0, "R5");
    settle();
    // R7 read-modify-write disabled
    cfg_rmw_en = 1'b0;
    send(32'h30, 64'h0000_0000_0000_BEEF, 8'h03, 8'h00, 1'b0, 1'b0, "R7");
    send(32'h38, 64'h0000_0000_00C0_0000, 8'h04, 8'h00, 1'b0, 1'b1, "R7");
    settle();
    cfg_rmw_en = 1'b1;
    // merge over the normal-mode partial write
    send(32'h30, 64'hAB00_0000_0000_0000, 8'h80, 8'h00, 1'b0, 1'b1, "R5");
    settle();
    repeat (4) @(negedge clk);
    chk(wq.size() == 0 && rq.size() == 0 && eq.size() == 0, "R4", "all expected commands seen",
        64'(wq.size() + rq.size() + eq.size()), 64'd0);
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule